// File: doc/BRIEF.md
# Cascadable Serial-In Latched Driver Bank

This block converts a serial bit stream into a bank of parallel driver controls. It suits print-head dot lines, relay banks and solenoid arrays. A shift chain takes one bit on every rising edge of a slow shift clock. The block finds that edge by sampling the shift clock on the fast system clock. Each chain stage feeds a latch, and each latch feeds an inverted output. A latch that holds a 1 pulls its output low, which turns the driver on. A latch that holds a 0 leaves its output high, which leaves the driver off.

The last chain stage is brought out as a serial output. Several blocks can therefore be chained into one long register, with all of them sharing the shift clock and the latch control. Two conditions blank every output to the off level at once: a high output-off input and a low power-good input. Neither condition stops shifting or the serial output. An asynchronous reset clears the chain and the latches, so every output stays off until real data has been shifted in and latched.

Top module: `serial_latch_driver`

## Requirements
- R1: A shift step occurs at a system clock edge where `shift_clk` is high and was low at the previous system clock edge. At that edge stage 1 takes `sin` and every other stage takes the value of the stage below it. Without such an edge the chain holds, and a `shift_clk` held high for many cycles gives exactly one step.
- R2: `sout` always equals the last chain stage. It changes only at a shift step, and neither `latch_open` nor `out_off` affects it.
- R3: At a system clock edge where `latch_open` is high, every latch takes the value its chain stage has after that edge. While `latch_open` is low, the latches hold their contents.
- R4: With `pwr_ok` high and `out_off` low, `drv_n[i]` is the inverse of latch i. Bit 0 carries stage 1, which holds the newest bit, and bit STAGES-1 carries the last stage.
- R5: While `out_off` is high, every bit of `drv_n` is 1 in the same cycle. Shifting and latching continue underneath.
- R6: While `pwr_ok` is low, every bit of `drv_n` is 1 in the same cycle, whatever `out_off` is.
- R7: While `rst_n` is low, the chain and the latches are cleared, so `drv_n` is all ones and `sout` is 0. If `shift_clk` is already high when reset is released, no shift step follows.
- R8: When `sout` of one block feeds `sin` of a second block with the same clocks, the pair behaves as a single chain of 2*STAGES stages.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples every input |
| rst_n | input | 1 | Asynchronous active-low reset |
| sin | input | 1 | Serial data in |
| shift_clk | input | 1 | Shift clock; a rising level causes one step |
| latch_open | input | 1 | High: latches follow the chain; low: latches hold |
| out_off | input | 1 | High forces all driver outputs off |
| pwr_ok | input | 1 | Low forces all driver outputs off |
| drv_n | output | STAGES | Active-low driver controls, bit 0 = newest stage |
| sout | output | 1 | Last chain stage, for cascading |

## Verification
A shift step lands at the same system clock edge that first sees `shift_clk` high. With `latch_open` high, the latch and therefore `drv_n` move at that same edge. `sout` moves at that edge as well. Blanking through `out_off` or `pwr_ok` is combinational, so it shows within the cycle in which the input changes. The bench drives inputs on the falling clock edge, updates its reference at the rising edge, and compares one nanosecond later, when every register and every combinational output has settled.

// File: rtl/sdrv_pkg.sv
package sdrv_pkg;

    localparam int unsigned SDRV_STAGES_DEF = 24;

    // What the output stage is doing in the current cycle.
    typedef enum logic [1:0] {
        OUT_LIVE      = 2'd0,
        OUT_BLANK_EN  = 2'd1,
        OUT_BLANK_PWR = 2'd2
    } out_mode_e;

endpackage

// File: rtl/sdrv_edge_detect.sv
module sdrv_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o
);

    typedef struct packed {
        logic lvl;
    } edge_state_t;

    edge_state_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.lvl = level_i;
    end

    // The reset value is 1, so a level that is already high when reset is released is not taken as an edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.lvl <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign rise_o = level_i & ~s_q.lvl;

    // R1: two rising edges cannot be reported in consecutive cycles.
    assert_single_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/sdrv_shift_chain.sv
module sdrv_shift_chain #(
    parameter int unsigned STAGES = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              din_i,
    output logic [STAGES-1:0] bits_o,
    output logic [STAGES-1:0] bits_next_o
);

    localparam int unsigned LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] bits;
    } chain_state_t;

    chain_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (step_i) begin
            s_d.bits = {s_q.bits[LAST-1:0], din_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.bits <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign bits_o      = s_q.bits;
    assign bits_next_o = s_d.bits;

    // R1: a step moves every stage up by one and takes in the serial bit.
    assert_step_moves_R1: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> (bits_o[LAST:1] == $past(bits_o[LAST-1:0])) && (bits_o[0] == $past(din_i)));

    // R1: without a step the chain holds.
    assert_idle_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(bits_o));

endmodule

// File: rtl/sdrv_latch_bank.sv
module sdrv_latch_bank #(
    parameter int unsigned STAGES = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open_i,
    input  logic [STAGES-1:0] d_i,
    output logic [STAGES-1:0] q_o
);

    typedef struct packed {
        logic [STAGES-1:0] held;
    } latch_state_t;

    latch_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (open_i) begin
            s_d.held = d_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.held <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign q_o = s_q.held;

    // R3: a closed latch holds its contents.
    assert_closed_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !open_i |=> $stable(q_o));

    // R3: an open latch follows its chain stage.
    assert_open_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        open_i |=> q_o == $past(d_i));

endmodule

// File: rtl/sdrv_out_stage.sv
module sdrv_out_stage
    import sdrv_pkg::*;
#(
    parameter int unsigned STAGES = 24
) (
    input  logic [STAGES-1:0] latch_i,
    input  logic              blank_i,
    input  logic              pwr_ok_i,
    output logic [STAGES-1:0] drv_n_o
);

    out_mode_e mode;

    // A power failure takes priority over the output-off input.
    always_comb begin
        if (!pwr_ok_i) begin
            mode = OUT_BLANK_PWR;
        end else if (blank_i) begin
            mode = OUT_BLANK_EN;
        end else begin
            mode = OUT_LIVE;
        end
    end

    always_comb begin
        case (mode)
            OUT_LIVE: drv_n_o = ~latch_i;
            default:  drv_n_o = '1;
        endcase
    end

endmodule

// File: rtl/serial_latch_driver.sv
module serial_latch_driver
    import sdrv_pkg::*;
#(
    parameter int unsigned STAGES = SDRV_STAGES_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sin,
    input  logic              shift_clk,
    input  logic              latch_open,
    input  logic              out_off,
    input  logic              pwr_ok,
    output logic [STAGES-1:0] drv_n,
    output logic              sout
);

    localparam int unsigned LAST = STAGES - 1;

    logic              step;
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] latch_q;

    sdrv_edge_detect u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (shift_clk),
        .rise_o  (step)
    );

    sdrv_shift_chain #(.STAGES(STAGES)) u_chain (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_i      (step),
        .din_i       (sin),
        .bits_o      (chain_q),
        .bits_next_o (chain_d)
    );

    sdrv_latch_bank #(.STAGES(STAGES)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .open_i (latch_open),
        .d_i    (chain_d),
        .q_o    (latch_q)
    );

    sdrv_out_stage #(.STAGES(STAGES)) u_out (
        .latch_i  (latch_q),
        .blank_i  (out_off),
        .pwr_ok_i (pwr_ok),
        .drv_n_o  (drv_n)
    );

    assign sout = chain_q[LAST];

    // R2: a step moves the serial output to the value of the stage below the last one.
    assert_sout_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> sout == $past(chain_q[LAST-1]));

    // R2: the serial output does not move without a step.
    assert_sout_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(sout));

    // R4: with power good and outputs enabled, each output is the inverse of its latch.
    assert_live_inverts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_ok && !out_off) |-> drv_n == ~latch_q);

    // R5: the output-off input blanks every output.
    assert_off_blanks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_off |-> &drv_n);

    // R6: a power failure blanks every output.
    assert_pwr_blanks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |-> &drv_n);

endmodule

// File: tb/tb_serial_latch_driver.sv
module tb_serial_latch_driver;

    localparam int N = 24;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sin = 1'b0;
    logic         sclk = 1'b0;
    logic         lat = 1'b0;
    logic         off_a = 1'b0;
    logic         off_b = 1'b0;
    logic         pwr = 1'b1;
    logic [N-1:0] drv_a, drv_b;
    logic         link, tail_sout;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    serial_latch_driver #(.STAGES(N)) dut (
        .clk(clk), .rst_n(rst_n), .sin(sin), .shift_clk(sclk),
        .latch_open(lat), .out_off(off_a), .pwr_ok(pwr),
        .drv_n(drv_a), .sout(link)
    );

    serial_latch_driver #(.STAGES(N)) u_tail (
        .clk(clk), .rst_n(rst_n), .sin(link), .shift_clk(sclk),
        .latch_open(lat), .out_off(off_b), .pwr_ok(pwr),
        .drv_n(drv_b), .sout(tail_sout)
    );

    // Behavioural reference: one 2N-long chain with 2N latches.
    int sr [2*N];
    int la [2*N];
    int sprev = 1;

    task automatic chk(input bit ok, input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2*N; i++) begin sr[i] = 0; la[i] = 0; end
            sprev = 1;
        end else begin
            if (sclk && sprev == 0) begin
                for (int i = 2*N-1; i > 0; i--) sr[i] = sr[i-1];
                sr[0] = int'(sin);
            end
            sprev = int'(sclk);
            if (lat) for (int i = 0; i < 2*N; i++) la[i] = sr[i];
        end
        #1;
        begin
            logic [N-1:0] ea, eb;
            string ta, tb;
            for (int i = 0; i < N; i++) begin
                ea[i] = (!pwr || off_a) ? 1'b1 : (la[i] == 0);
                eb[i] = (!pwr || off_b) ? 1'b1 : (la[N+i] == 0);
            end
            ta = !rst_n ? "R7" : (!pwr ? "R6" : (off_a ? "R5" : "R4"));
            tb = !rst_n ? "R7" : "R8";
            chk(drv_a === ea, ta, drv_a, ea);
            chk(drv_b === eb, tb, drv_b, eb);
            chk(link === logic'(sr[N-1]), "R2", N'(link), N'(sr[N-1]));
            chk(tail_sout === logic'(sr[2*N-1]), "R8", N'(tail_sout), N'(sr[2*N-1]));
        end
    end

    task automatic shift_bit(input logic b);
        @(negedge clk); sin = b; sclk = 1'b1;
        @(negedge clk); sclk = 1'b0;
    endtask

    initial begin
        #400000;
        checks++; errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 chk(drv_a === '1 && link === 1'b0, "R7", drv_a, '1);
        @(negedge clk); rst_n = 1'b1;

        // R1: a single 1 walks to the last stage with the latches open.
        lat = 1'b1;
        shift_bit(1'b1);
        repeat (N-1) shift_bit(1'b0);
        #1 chk(drv_a === 24'h7FFFFF, "R1", drv_a, 24'h7FFFFF);
        chk(link === 1'b1, "R2", N'(link), 1);

        // R8: one more step carries the bit into the second block.
        shift_bit(1'b0);
        #1 chk(drv_b === 24'hFFFFFE, "R8", drv_b, 24'hFFFFFE);

        // R3: closed latches hold while ones are shifted in.
        @(negedge clk); lat = 1'b0;
        repeat (N) shift_bit(1'b1);
        #1 chk(drv_a === '1, "R3", drv_a, '1);
        chk(link === 1'b1, "R2", N'(link), 1);
        @(negedge clk); lat = 1'b1;
        @(negedge clk);
        #1 chk(drv_a === '0, "R3", drv_a, '0);

        // R5: output-off blanks at once and shifting continues.
        off_a = 1'b1;
        #1 chk(drv_a === '1, "R5", drv_a, '1);
        shift_bit(1'b0);
        @(negedge clk); off_a = 1'b0;
        #1 chk(drv_a === 24'h000001, "R5", drv_a, 24'h000001);

        // R6: power failure blanks both blocks.
        @(negedge clk); pwr = 1'b0; off_b = 1'b0;
        #1 chk(drv_a === '1, "R6", drv_a, '1);
        chk(drv_b === '1, "R6", drv_b, '1);
        @(negedge clk); pwr = 1'b1;

        // R1: a shift clock held high gives one step only.
        repeat (N) shift_bit(1'b0);
        @(negedge clk); sin = 1'b1; sclk = 1'b1;
        repeat (5) @(negedge clk);
        sclk = 1'b0;
        @(negedge clk);
        #1 chk(drv_a === 24'hFFFFFE, "R1", drv_a, 24'hFFFFFE);

        // R7: reset released while the shift clock is high gives no step.
        @(negedge clk); rst_n = 1'b0; sclk = 1'b1; sin = 1'b1;
        #1 chk(drv_a === '1 && link === 1'b0, "R7", drv_a, '1);
        @(negedge clk); rst_n = 1'b1;
        repeat (3) @(negedge clk);
        #1 chk(drv_a === '1 && link === 1'b0, "R7", drv_a, '1);
        @(negedge clk); sclk = 1'b0;
        repeat (4) shift_bit(1'b1);
        repeat (2) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule